// File: doc/BRIEF.md
# Multiplexed Burst Bus Master

This block takes one word-oriented request at a time from a core. It runs that request as a single transaction on a 32-bit bus that carries both address and data on the same lines. The request gives a word address, a transfer count of one to four, a region width of 32, 16 or 8 bits, lane enables, a direction and a lock flag. The controller acknowledges the request and latches it. It then presents the address for exactly one cycle. The two lowest bus bits in that cycle carry the transfer count, so an external decoder knows the burst length before data starts. The controller then steps through the data transfers, paced by a single active-low ready input.

The same ready input also has a second job after the final transfer. While it is held low, the controller stays in recovery and holds off the next address. An external master can ask for the bus with a hold request. The controller grants it only from idle and never during a locked sequence, and it then floats every output it drives. Output enables come out as explicit tri-state controls: one for the shared address/data lines and one for the strobes.

Top module: `mbb_bus_master`

## Requirements
- R1: While reset is low and after its release, the controller is idle, with ale=0, adsN=1, denN=1, blastN=1, lockN=1, holdAck=0, adOe=0, ctrlOe=1 and beN=4'hF.
- R2: A request seen in idle is acknowledged in that same cycle (reqAck=1). The next cycle is the single address cycle: ale=1, adsN=0, adOe=1, and adOut carries the latched word address in bits 31:2 and the count code in bits 1:0 (0 means 1 transfer, 3 means 4 transfers). The core's request inputs may change after the acknowledge.
- R3: A data cycle with rdyN=1 is a wait state and is repeated. beatValid is 1 exactly in data cycles with rdyN=0, and then rdData equals adIn.
- R4: After the last transfer is accepted, the controller stays in recovery (adsN=1, adOe=0, no acknowledge) for as long as rdyN=0. It returns to idle in the cycle after it samples rdyN=1.
- R5: aPart carries bits 3:2 of the current transfer address. That address starts at the request address and advances by 4, 2 or 1 for width codes 0 (32-bit), 1 (16-bit) and 2 (8-bit) on each accepted transfer.
- R6: beN is valid from the address cycle through the last data cycle. For width 0 it is the inverted lane enables. For width 1 it is {~en[3], 1, addr bit 1, ~en[0]}. For width 2 it is {1, 1, addr bits 1:0}. Only the address bits in it change during a burst.
- R7: denN is 0 from the first to the last data cycle and 1 elsewhere. blastN is 0 only in the final transfer, including its wait states.
- R8: busWr and busXmit equal the request direction (1 = write) from the address cycle through all data cycles. During data cycles adOe equals busWr, and on writes adOut equals wrData.
- R9: A hold request seen in idle wins over a pending request (no acknowledge). The next cycle has holdAck=1, ctrlOe=0 and adOe=0. holdAck drops in the cycle after holdReq is released, and the controller is idle again.
- R10: lockN goes to 0 in the address cycle of a request with reqLock=1. It stays 0 through any later requests and the idle cycles between them. It goes to 1 in the final transfer of the first request with reqLock=0. No hold is granted while lockN=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core request present |
| reqAddr | input | 32 | Byte address of first transfer |
| reqCount | input | 2 | Transfers minus one |
| reqWidth | input | 2 | Region width: 0=32, 1=16, 2=8 bit |
| reqByteEn | input | 4 | Active-high lane enables |
| reqWrite | input | 1 | 1 = write |
| reqLock | input | 1 | Request belongs to a locked sequence that continues |
| reqAck | output | 1 | Request accepted this cycle |
| wrData | input | 32 | Write data for the current transfer |
| rdData | output | 32 | Read data for the current transfer |
| beatValid | output | 1 | A transfer is accepted this cycle |
| adIn | input | 32 | Shared bus, input side |
| adOut | output | 32 | Shared bus, output side |
| adOe | output | 1 | Drive enable for adOut |
| ale | output | 1 | Address latch enable, active high |
| adsN | output | 1 | Address strobe, active low |
| beN | output | 4 | Byte enables / low address bits, active low |
| aPart | output | 2 | Partial address bits 3:2 |
| busWr | output | 1 | Write/read indication |
| busXmit | output | 1 | Transceiver direction, 1 = transmit |
| denN | output | 1 | Data enable, active low |
| blastN | output | 1 | Last transfer, active low |
| rdyN | input | 1 | Ready during data, recovery extender after it, active low |
| lockN | output | 1 | Atomic lock, active low |
| holdReq | input | 1 | External master requests the bus |
| holdAck | output | 1 | Bus relinquished |
| ctrlOe | output | 1 | Drive enable for the strobes |

## Verification
The bench sweeps every width, transfer count, direction and a zero or one wait-state pattern, then checks the strobes and the partial address cycle by cycle. A controller that advanced the address on a wait state, or used the wrong step for a narrow region, would put the wrong aPart or beN on a later transfer. A controller that dropped burst-last during a stretched final transfer would fail the blastN check. The bench holds ready low through recovery while a request is pending, which catches a controller that starts the next address too early. It races hold against a request in idle and tries hold between the two halves of a locked pair, so a controller that granted hold during a lock, or released lock one transfer too soon, would be reported.

// File: rtl/mbb_pkg.sv
`timescale 1ns/1ps
package mbb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_RECOV, ST_HOLD
  } busState_t;

  typedef struct packed {
    logic loadReq;
    logic advance;
    logic addrPhase;
    logic dataPhase;
  } busStrobe_t;

  localparam logic [1:0] WID_32 = 2'd0;
  localparam logic [1:0] WID_16 = 2'd1;
endpackage

// File: rtl/mbb_ctrl.sv
`timescale 1ns/1ps
module mbb_ctrl
  import mbb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqLock,
  input  logic       rdyN,
  input  logic       holdReq,
  input  logic       lastBeat,
  output busStrobe_t strb,
  output logic       reqAck,
  output logic       ale,
  output logic       adsN,
  output logic       denN,
  output logic       blastN,
  output logic       lockN,
  output logic       holdAck,
  output logic       ctrlOe,
  output logic       beatValid
);
  busState_t state, nextState;
  logic lockSeq, curLock;
  logic grantHold, accept, beatDone, finalDone;

  assign grantHold = (state == ST_IDLE) && holdReq && !lockSeq;
  assign accept    = (state == ST_IDLE) && reqValid && !grantHold;
  assign beatDone  = (state == ST_DATA) && !rdyN;
  assign finalDone = beatDone && lastBeat;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (grantHold) nextState = ST_HOLD;
                else if (accept) nextState = ST_ADDR;
      ST_ADDR:  nextState = ST_DATA;
      ST_DATA:  if (finalDone) nextState = ST_RECOV;
      ST_RECOV: if (rdyN) nextState = ST_IDLE;
      ST_HOLD:  if (!holdReq) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lockSeq <= 1'b0;
      curLock <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) begin
        curLock <= reqLock;
        if (reqLock) lockSeq <= 1'b1;
      end else if (finalDone && !curLock) begin
        lockSeq <= 1'b0;
      end
    end
  end

  assign strb.loadReq   = accept;
  assign strb.advance   = beatDone;
  assign strb.addrPhase = (state == ST_ADDR);
  assign strb.dataPhase = (state == ST_DATA);

  assign reqAck    = accept;
  assign ale       = (state == ST_ADDR);
  assign adsN      = !(state == ST_ADDR);
  assign denN      = !(state == ST_DATA);
  assign blastN    = !((state == ST_DATA) && lastBeat);
  assign lockN     = !(lockSeq && !((state == ST_DATA) && lastBeat && !curLock));
  assign holdAck   = (state == ST_HOLD);
  assign ctrlOe    = (state != ST_HOLD);
  assign beatValid = beatDone;
endmodule

// File: rtl/mbb_dpath.sv
`timescale 1ns/1ps
module mbb_dpath
  import mbb_pkg::*;
#(
  parameter int BusW = 32,
  parameter int CntW = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  busStrobe_t      strb,
  input  logic [BusW-1:0] reqAddr,
  input  logic [CntW-1:0] reqCount,
  input  logic [1:0]      reqWidth,
  input  logic [3:0]      reqByteEn,
  input  logic            reqWrite,
  input  logic [BusW-1:0] wrData,
  input  logic [BusW-1:0] adIn,
  output logic [BusW-1:0] adOut,
  output logic            adOe,
  output logic [3:0]      beN,
  output logic [1:0]      aPart,
  output logic            busWr,
  output logic            busXmit,
  output logic            lastBeat,
  output logic [BusW-1:0] rdData
);
  localparam int LowW = 4;

  logic [BusW-1:CntW] addrQ;
  logic [CntW-1:0]    cntQ, beatQ;
  logic [1:0]         widQ;
  logic [3:0]         enQ;
  logic               wrQ;
  logic [LowW-1:0]    lowQ, stepV;

  always_comb begin
    case (widQ)
      WID_32:  stepV = 4'd4;
      WID_16:  stepV = 4'd2;
      default: stepV = 4'd1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      cntQ  <= '0;
      beatQ <= '0;
      widQ  <= WID_32;
      enQ   <= '0;
      wrQ   <= 1'b0;
      lowQ  <= '0;
    end else if (strb.loadReq) begin
      addrQ <= reqAddr[BusW-1:CntW];
      cntQ  <= reqCount;
      beatQ <= '0;
      widQ  <= reqWidth;
      enQ   <= reqByteEn;
      wrQ   <= reqWrite;
      lowQ  <= reqAddr[LowW-1:0];
    end else if (strb.advance) begin
      beatQ <= beatQ + 1'b1;
      lowQ  <= lowQ + stepV;
    end
  end

  always_comb begin
    case (widQ)
      WID_32:  beN = ~enQ;
      WID_16:  beN = {~enQ[3], 1'b1, lowQ[1], ~enQ[0]};
      default: beN = {2'b11, lowQ[1:0]};
    endcase
  end

  assign lastBeat = (beatQ == cntQ);
  assign aPart    = lowQ[3:2];
  assign adOut    = strb.addrPhase ? {addrQ, cntQ} : wrData;
  assign adOe     = strb.addrPhase || (strb.dataPhase && wrQ);
  assign busWr    = wrQ;
  assign busXmit  = wrQ;
  assign rdData   = adIn;
endmodule

// File: rtl/mbb_bus_master.sv
`timescale 1ns/1ps
module mbb_bus_master
  import mbb_pkg::*;
#(
  parameter int BusW = 32,
  parameter int CntW = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [BusW-1:0] reqAddr,
  input  logic [CntW-1:0] reqCount,
  input  logic [1:0]      reqWidth,
  input  logic [3:0]      reqByteEn,
  input  logic            reqWrite,
  input  logic            reqLock,
  output logic            reqAck,
  input  logic [BusW-1:0] wrData,
  output logic [BusW-1:0] rdData,
  output logic            beatValid,
  input  logic [BusW-1:0] adIn,
  output logic [BusW-1:0] adOut,
  output logic            adOe,
  output logic            ale,
  output logic            adsN,
  output logic [3:0]      beN,
  output logic [1:0]      aPart,
  output logic            busWr,
  output logic            busXmit,
  output logic            denN,
  output logic            blastN,
  input  logic            rdyN,
  output logic            lockN,
  input  logic            holdReq,
  output logic            holdAck,
  output logic            ctrlOe
);
  busStrobe_t strb;
  logic       lastBeat;

  mbb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLock(reqLock),
    .rdyN(rdyN), .holdReq(holdReq), .lastBeat(lastBeat), .strb(strb),
    .reqAck(reqAck), .ale(ale), .adsN(adsN), .denN(denN), .blastN(blastN),
    .lockN(lockN), .holdAck(holdAck), .ctrlOe(ctrlOe), .beatValid(beatValid)
  );

  mbb_dpath #(.BusW(BusW), .CntW(CntW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqCount(reqCount), .reqWidth(reqWidth), .reqByteEn(reqByteEn),
    .reqWrite(reqWrite), .wrData(wrData), .adIn(adIn), .adOut(adOut),
    .adOe(adOe), .beN(beN), .aPart(aPart), .busWr(busWr),
    .busXmit(busXmit), .lastBeat(lastBeat), .rdData(rdData)
  );
endmodule

// File: rtl/mbb_chk.sv
`timescale 1ns/1ps
module mbb_chk (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic adsN,
  input logic denN,
  input logic blastN,
  input logic rdyN,
  input logic lockN,
  input logic holdAck,
  input logic ctrlOe,
  input logic adOe,
  input logic busXmit
);
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale); // R2
  AST_ALE_WITH_ADS: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (!adsN && denN)); // R2
  AST_BLAST_IN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !blastN |-> !denN); // R7
  AST_BLAST_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (!blastN && rdyN) |=> !blastN); // R7
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !denN |=> (denN || $stable(busXmit))); // R8
  AST_RECOV_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (!blastN && !rdyN) |=> (!ale && denN)); // R4
  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (!ctrlOe && !adOe && denN)); // R9
  AST_HOLD_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> lockN); // R10
endmodule

bind mbb_bus_master mbb_chk u_chk (
  .clk(clk), .rstN(rstN), .ale(ale), .adsN(adsN), .denN(denN),
  .blastN(blastN), .rdyN(rdyN), .lockN(lockN), .holdAck(holdAck),
  .ctrlOe(ctrlOe), .adOe(adOe), .busXmit(busXmit)
);

// File: tb/tb_mbb_bus_master.sv
`timescale 1ns/1ps
module tb_mbb_bus_master;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, reqValid, reqWrite, reqLock, reqAck, beatValid, adOe, ale, adsN;
  logic busWr, busXmit, denN, blastN, rdyN, lockN, holdReq, holdAck, ctrlOe;
  logic [31:0] reqAddr, wrData, rdData, adIn, adOut;
  logic [1:0]  reqCount, reqWidth, aPart;
  logic [3:0]  reqByteEn, beN;

  int vectors = 0;
  int miscompares = 0;

  mbb_bus_master dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqCount(reqCount), .reqWidth(reqWidth), .reqByteEn(reqByteEn),
    .reqWrite(reqWrite), .reqLock(reqLock), .reqAck(reqAck),
    .wrData(wrData), .rdData(rdData), .beatValid(beatValid), .adIn(adIn),
    .adOut(adOut), .adOe(adOe), .ale(ale), .adsN(adsN), .beN(beN),
    .aPart(aPart), .busWr(busWr), .busXmit(busXmit), .denN(denN),
    .blastN(blastN), .rdyN(rdyN), .lockN(lockN), .holdReq(holdReq),
    .holdAck(holdAck), .ctrlOe(ctrlOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic nextCycle;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] expBe(input int wid, input logic [3:0] en, input logic [3:0] low);
    if (wid == 0) return ~en;
    if (wid == 1) return {~en[3], 1'b1, low[1], ~en[0]};
    return {2'b11, low[1:0]};
  endfunction

  task automatic runTxn(input logic [31:0] addr, input int cnt, input int wid,
                        input bit wr, input logic [3:0] en, input int nw,
                        input int nrec, input bit lockIn, input bit lk);
    int step;
    logic [3:0] low;
    step = (wid == 0) ? 4 : (wid == 1) ? 2 : 1;
    reqValid = 1; reqAddr = addr; reqCount = cnt[1:0]; reqWidth = wid[1:0];
    reqByteEn = en; reqWrite = wr; reqLock = lk; rdyN = 1;
    #1 chk("R2 ack", {31'd0, reqAck}, 32'd1);
    nextCycle;
    reqValid = 0; reqAddr = ~addr; reqWrite = !wr; reqByteEn = ~en; reqLock = 0;
    #1;
    chk("R2 ale", {31'd0, ale}, 32'd1);
    chk("R2 adsN", {31'd0, adsN}, 32'd0);
    chk("R2 adOut", adOut, {addr[31:2], cnt[1:0]});
    chk("R2 adOe", {31'd0, adOe}, 32'd1);
    chk("R7 denN addr", {31'd0, denN}, 32'd1);
    chk("R5 aPart addr", {30'd0, aPart}, {30'd0, addr[3:2]});
    chk("R6 beN addr", {28'd0, beN}, {28'd0, expBe(wid, en, addr[3:0])});
    chk("R8 busWr addr", {31'd0, busWr}, {31'd0, wr});
    chk("R8 busXmit addr", {31'd0, busXmit}, {31'd0, wr});
    chk("R10 lockN addr", {31'd0, lockN}, {31'd0, !(lockIn || lk)});
    for (int b = 0; b <= cnt; b++) begin
      low = addr[3:0] + 4'(b * step);
      for (int w = 0; w <= nw; w++) begin
        nextCycle;
        rdyN = (w < nw);
        adIn = 32'hC0DE_0000 + b;
        wrData = 32'hA5A5_0000 + b;
        #1;
        chk("R7 denN", {31'd0, denN}, 32'd0);
        chk("R7 blastN", {31'd0, blastN}, {31'd0, b != cnt});
        chk("R2 ale data", {31'd0, ale}, 32'd0);
        chk("R5 aPart", {30'd0, aPart}, {30'd0, low[3:2]});
        chk("R6 beN", {28'd0, beN}, {28'd0, expBe(wid, en, low)});
        chk("R8 busXmit", {31'd0, busXmit}, {31'd0, wr});
        chk("R8 adOe", {31'd0, adOe}, {31'd0, wr});
        if (wr) chk("R8 adOut wr", adOut, 32'hA5A5_0000 + b);
        chk("R3 beatValid", {31'd0, beatValid}, {31'd0, !rdyN});
        if (!wr && !rdyN) chk("R3 rdData", rdData, 32'hC0DE_0000 + b);
        chk("R10 lockN data", {31'd0, lockN},
            {31'd0, !((lockIn || lk) && !(b == cnt && !lk))});
      end
    end
    for (int r = 0; r <= nrec; r++) begin
      nextCycle;
      rdyN = (r == nrec);
      reqValid = 1;
      #1;
      chk("R4 no ack", {31'd0, reqAck}, 32'd0);
      chk("R4 adsN", {31'd0, adsN}, 32'd1);
      chk("R4 ale", {31'd0, ale}, 32'd0);
      chk("R4 adOe", {31'd0, adOe}, 32'd0);
      chk("R7 denN recov", {31'd0, denN}, 32'd1);
      chk("R10 lockN recov", {31'd0, lockN}, {31'd0, !lk});
    end
    nextCycle;
    reqValid = 0; rdyN = 1;
    #1 chk("R4 idle", {31'd0, adsN}, 32'd1);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rstN = 0; reqValid = 0; reqAddr = '0; reqCount = '0; reqWidth = '0;
    reqByteEn = '0; reqWrite = 0; reqLock = 0; wrData = '0; adIn = '0;
    rdyN = 1; holdReq = 0;
    repeat (3) nextCycle;
    chk("R1 ale", {31'd0, ale}, 32'd0);
    chk("R1 adsN", {31'd0, adsN}, 32'd1);
    chk("R1 denN", {31'd0, denN}, 32'd1);
    chk("R1 blastN", {31'd0, blastN}, 32'd1);
    chk("R1 lockN", {31'd0, lockN}, 32'd1);
    chk("R1 holdAck", {31'd0, holdAck}, 32'd0);
    chk("R1 adOe", {31'd0, adOe}, 32'd0);
    chk("R1 ctrlOe", {31'd0, ctrlOe}, 32'd1);
    chk("R1 beN", {28'd0, beN}, 32'hF);
    rstN = 1;
    nextCycle;
    chk("R1 idle after", {31'd0, adsN}, 32'd1);

    // Sweep over width, count, direction and wait pattern
    for (int wid = 0; wid < 3; wid++)
      for (int cnt = 0; cnt < 4; cnt++)
        for (int wr = 0; wr < 2; wr++)
          for (int nw = 0; nw < 2; nw++) begin
            logic [31:0] a;
            a = 32'h1234_5600 ^ (32'(wid * 16 + cnt * 4 + wr * 2 + nw) << 8);
            a[3:0] = (wid == 0) ? 4'h0 : (wid == 1) ? 4'h8 : 4'hC;
            runTxn(a, cnt, wid, wr[0], 4'(4'b0101 ^ cnt ^ (wid << 1)), nw, nw, 0, 0);
          end

    // R9: hold beats a pending request, floats outputs, releases
    reqValid = 1; holdReq = 1; reqAddr = 32'h0000_1000;
    #1 chk("R9 no ack", {31'd0, reqAck}, 32'd0);
    nextCycle;
    reqValid = 0;
    #1;
    chk("R9 holdAck", {31'd0, holdAck}, 32'd1);
    chk("R9 ctrlOe", {31'd0, ctrlOe}, 32'd0);
    chk("R9 adOe", {31'd0, adOe}, 32'd0);
    nextCycle;
    holdReq = 0;
    #1 chk("R9 holdAck held", {31'd0, holdAck}, 32'd1);
    nextCycle;
    chk("R9 released", {31'd0, holdAck}, 32'd0);
    chk("R9 ctrlOe back", {31'd0, ctrlOe}, 32'd1);
    runTxn(32'h0000_2000, 1, 0, 1, 4'hF, 0, 0, 0, 0);

    // R10: locked read, hold refused, closing burst write releases lock
    runTxn(32'h0000_3000, 0, 0, 0, 4'hF, 1, 0, 0, 1);
    holdReq = 1;
    #1;
    nextCycle;
    chk("R10 hold refused", {31'd0, holdAck}, 32'd0);
    chk("R10 lock idle", {31'd0, lockN}, 32'd0);
    nextCycle;
    chk("R10 hold refused 2", {31'd0, holdAck}, 32'd0);
    holdReq = 0;
    runTxn(32'h0000_3000, 2, 0, 1, 4'hF, 1, 1, 1, 0);
    holdReq = 1;
    #1;
    nextCycle;
    chk("R10 hold after unlock", {31'd0, holdAck}, 32'd1);
    holdReq = 0;
    nextCycle;
    nextCycle;
    chk("R9 idle again", {31'd0, holdAck}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule